// File: doc/BRIEF.md
# Read Data Slice Compactor

The block sits on the read side of a parallel interface that runs faster than the core. On every core clock it takes one beat that holds several external time slices of read data, along with an enable bit for each slice that says whether that slice carries real data. It drops the disabled slices and packs the enabled ones toward the least significant end, keeping their original order. It produces a valid mask of matching width, which is a contiguous run of ones that starts at bit 0. The result appears a fixed, configurable number of core cycles later, so the valid timing stays in step with the enable timing.

Slice `k` of any mask or data bus is the `k`-th time slice, and slice 0 (the LSB side) is the earliest one received. Packing works within a single beat. Spare capacity in one beat is never filled with slices from the next beat. An unaligned read that spans two beats therefore shows up as two partial beats.

The output is a stream qualified by the per-slice valid mask. There is no ready signal and no back-pressure, because captured read data cannot be stalled. The consumer must take every beat in the cycle it appears, and a beat whose mask is zero carries nothing.

Top module: `rd_slice_compactor`

## Requirements
- R1: Each enabled input slice appears on the output in lane j, where j is the number of enabled slices below it in the same beat. Enabled slices therefore keep their relative order, with the earliest enabled slice in lane 0.
- R2: An all-ones enable mask (4'hf for four slices) gives an all-ones valid mask, and the data passes through in its original slice order.
- R3: The valid mask is always a contiguous run of ones that starts at bit 0 (4'h0, 4'h1, 4'h3, 4'h7 or 4'hf for four slices).
- R4: The number of ones in the valid mask equals the number of ones in the enable mask of the beat it belongs to.
- R5: Output data lanes whose valid bit is 0 are driven to zero.
- R6: A synchronous reset clears every pipeline stage. After reset, the valid mask and the data stay zero until the first beat taken after reset reaches the output.
- R7: A beat presented at the clock edge where it is sampled appears on the outputs after exactly DELAY core clock edges, counting that edge. DELAY is at least 1.
- R8: No carry between beats: an enable of 4'he followed by 4'h1 gives a valid of 4'h7 and then a valid of 4'h1.
- R9: An all-zero enable mask gives an all-zero valid mask and all-zero data for that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| in_en | input | NSLICE | Per-slice enable for the incoming beat; bit 0 is the earliest slice |
| in_data | input | NSLICE*SW | Incoming beat; slice k is bits [k*SW +: SW] |
| out_vld | output | NSLICE | Per-slice valid mask, a contiguous run of ones from bit 0 |
| out_data | output | NSLICE*SW | Compacted beat, with zeros above the valid run |

## Verification
The assertions assume that `in_en` is a known value on every clock edge outside reset. They also assume that DELAY is at least 1, so that the count they carry along for each beat lines up with the output stage. The bench drives `in_en` and `in_data` only at falling edges and always to defined values, including during reset, where it sets a full mask to show that reset wins. All sixteen enable masks are swept. The bench then runs the two-beat unaligned pair and a long stretch of random masks, and follows with zero-enable beats that drain the pipeline.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned RSC_SLICES_DEF = 4;
  localparam int unsigned RSC_SLICE_W_DEF = 16;
  localparam int unsigned RSC_DELAY_DEF = 2;

  function automatic int unsigned rsc_cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rsc_pack.sv
module rsc_pack #(
  parameter int unsigned NSLICE = 4,
  parameter int unsigned SW = 16,
  localparam int unsigned W = NSLICE * SW
) (
  input  logic [NSLICE-1:0] en,
  input  logic [W-1:0]      din,
  output logic [NSLICE-1:0] vld,
  output logic [W-1:0]      dout
);
  int unsigned fill;

  always_comb begin
    dout = '0;
    fill = 0;
    for (int i = 0; i < NSLICE; i++) begin
      if (en[i]) begin
        dout[fill*SW +: SW] = din[i*SW +: SW];
        fill = fill + 1;
      end
    end
    for (int k = 0; k < NSLICE; k++) begin
      vld[k] = (k < fill);
    end
  end
endmodule

// File: rtl/rsc_pipe.sv
module rsc_pipe #(
  parameter int unsigned NSLICE = 4,
  parameter int unsigned SW = 16,
  parameter int unsigned DELAY = 2,
  localparam int unsigned W = NSLICE * SW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSLICE-1:0] vld_i,
  input  logic [W-1:0]      dat_i,
  output logic [NSLICE-1:0] vld_o,
  output logic [W-1:0]      dat_o
);
  logic [NSLICE-1:0] vld_q [DELAY];
  logic [W-1:0]      dat_q [DELAY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DELAY; j++) begin
        vld_q[j] <= '0;
        dat_q[j] <= '0;
      end
    end else begin
      vld_q[0] <= vld_i;
      dat_q[0] <= dat_i;
      for (int j = 1; j < DELAY; j++) begin
        vld_q[j] <= vld_q[j-1];
        dat_q[j] <= dat_q[j-1];
      end
    end
  end

  assign vld_o = vld_q[DELAY-1];
  assign dat_o = dat_q[DELAY-1];
endmodule

// File: rtl/rd_slice_compactor.sv
module rd_slice_compactor
  import rsc_pkg::*;
#(
  parameter int unsigned NSLICE = RSC_SLICES_DEF,
  parameter int unsigned SW = RSC_SLICE_W_DEF,
  parameter int unsigned DELAY = RSC_DELAY_DEF,
  localparam int unsigned W = NSLICE * SW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSLICE-1:0] in_en,
  input  logic [W-1:0]      in_data,
  output logic [NSLICE-1:0] out_vld,
  output logic [W-1:0]      out_data
);
  logic [NSLICE-1:0] pk_vld;
  logic [W-1:0]      pk_data;

  rsc_pack #(.NSLICE(NSLICE), .SW(SW)) u_pack (
    .en  (in_en),
    .din (in_data),
    .vld (pk_vld),
    .dout(pk_data)
  );

  rsc_pipe #(.NSLICE(NSLICE), .SW(SW), .DELAY(DELAY)) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .vld_i(pk_vld),
    .dat_i(pk_data),
    .vld_o(out_vld),
    .dat_o(out_data)
  );
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk
  import rsc_pkg::*;
#(
  parameter int unsigned NSLICE = 4,
  parameter int unsigned SW = 16,
  parameter int unsigned DELAY = 2,
  localparam int unsigned W = NSLICE * SW,
  localparam int unsigned CW = rsc_cnt_w(NSLICE),
  localparam int unsigned SCW = rsc_cnt_w(DELAY)
) (
  input logic              clk,
  input logic              rst,
  input logic [NSLICE-1:0] in_en,
  input logic [NSLICE-1:0] out_vld,
  input logic [W-1:0]      out_data
);
  logic [CW-1:0]  cnt_q [DELAY];
  logic [SCW-1:0] since_rst;
  logic [W-1:0]   lane_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      for (int j = 0; j < DELAY; j++) cnt_q[j] <= '0;
    end else begin
      if (since_rst < SCW'(DELAY)) since_rst <= since_rst + 1'b1;
      cnt_q[0] <= CW'($countones(in_en));
      for (int j = 1; j < DELAY; j++) cnt_q[j] <= cnt_q[j-1];
    end
  end

  always_comb begin
    for (int k = 0; k < NSLICE; k++) lane_mask[k*SW +: SW] = {SW{out_vld[k]}};
  end

  // R3: valid mask is a run of ones from bit 0
  p_contig_r3: assert property (@(posedge clk) disable iff (rst)
    ((out_vld + 1'b1) & out_vld) == '0);

  // R4, R2, R8: valid count follows the enable count DELAY beats earlier (R7)
  p_count_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(out_vld) == int'(cnt_q[DELAY-1]));

  // R5: lanes above the valid run are zero
  p_zero_lanes_r5: assert property (@(posedge clk) disable iff (rst)
    (out_data & ~lane_mask) == '0);

  // R6: nothing emerges before the first post-reset beat arrives
  p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst < SCW'(DELAY)) |-> (out_vld == '0 && out_data == '0));

  // R9: empty beat stays empty
  p_empty_beat_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q[DELAY-1] == '0) |-> (out_data == '0));
endmodule

bind rd_slice_compactor rsc_chk #(.NSLICE(NSLICE), .SW(SW), .DELAY(DELAY)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_en   (in_en),
  .out_vld (out_vld),
  .out_data(out_data)
);

// File: tb/sim_rd_slice_compactor.sv
module sim_rd_slice_compactor;
  localparam int NS = 4;
  localparam int SW = 16;
  localparam int DL = 3;
  localparam int W = NS * SW;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 200;
  localparam int TOT = 16 + 2 + NRAND;
  localparam int DRAIN = DL + 2;
  localparam int ALL = TOT + DRAIN;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] in_en = '0;
  logic [W-1:0]  in_data = '0;
  logic [NS-1:0] out_vld;
  logic [W-1:0]  out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [NS-1:0] exp_vld [ALL];
  logic [W-1:0]  exp_dat [ALL];

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_slice_compactor #(.NSLICE(NS), .SW(SW), .DELAY(DL)) u0 (
    .clk(clk), .rst(rst), .in_en(in_en), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: walk the slices and append enabled ones to the next free lane
  task automatic model(input logic [NS-1:0] en, input logic [W-1:0] d,
                       output logic [NS-1:0] v, output logic [W-1:0] o);
    int n;
    n = 0;
    o = '0;
    for (int s = 0; s < NS; s++) begin
      if (en[s]) begin
        o[n*SW +: SW] = d[s*SW +: SW];
        n++;
      end
    end
    v = NS'((1 << n) - 1);
  endtask

  task automatic check_out(input int b);
    logic [NS-1:0] ev;
    logic [W-1:0] ed;
    string tg;
    if (b < 0) begin
      chk(out_vld == '0 && out_data == '0, "R6 quiet before first beat",
          {out_vld, out_data}, '0);
      return;
    end
    ev = exp_vld[b];
    ed = exp_dat[b];
    if (b == 16 || b == 17) tg = "R8";
    else if (ev == '1) tg = "R2";
    else if (ev == '0) tg = "R9";
    else tg = "R4";
    chk(out_vld == ev, {tg, " R7 valid mask"}, W'(out_vld), W'(ev));
    chk(out_data == ed, {tg, " R1 packed data"}, out_data, ed);
    chk(((out_vld + 1'b1) & out_vld) == '0, "R3 contiguous valid",
        W'(out_vld), W'(ev));
    for (int k = 0; k < NS; k++) begin
      if (!out_vld[k])
        chk(out_data[k*SW +: SW] == '0, "R5 zero upper lane",
            W'(out_data[k*SW +: SW]), '0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] e;
    logic [W-1:0] d;
    // Full enable held during reset must not leak through (R6)
    in_en = '1;
    in_data = {W/32{32'hA5A5_5A5A}};
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_vld == '0 && out_data == '0, "R6 reset state", {out_vld, out_data}, '0);
    rst = 1'b0;
    for (int b = 0; b < ALL; b++) begin
      if (b < 16) begin
        e = NS'(b);
        for (int s = 0; s < NS; s++) d[s*SW +: SW] = SW'(16'h1100 * (s + 1) + b);
      end else if (b == 16) begin
        e = 4'he;
        d = {$urandom, $urandom};
      end else if (b == 17) begin
        e = 4'h1;
        d = {$urandom, $urandom};
      end else if (b < TOT) begin
        e = NS'($urandom);
        d = {$urandom, $urandom};
      end else begin
        e = '0;
        d = {$urandom, $urandom};
      end
      in_en = e;
      in_data = d;
      model(e, d, exp_vld[b], exp_dat[b]);
      @(posedge clk);
      @(negedge clk);
      check_out(b - DL + 1);
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule